// File: doc/BRIEF.md
# Prescaled 8-bit Timer/Counter

The block is an 8-bit up-counter on a small register bus. It advances either once per instruction cycle (one `clk_i` period) or on edges of an external pin. The pin is brought into the clock domain by a two-stage synchronizer, and its rising or falling edge is chosen by a config input. An 8-bit prescaler sits beside the counter. A config input assigns it either to the counter's increment path or to a watchdog time-base path, and never to both. A 3-bit rate field selects which prescaler stage ends a period. The prescaler's contents cannot be seen from the bus.

When the counter wraps from FFh to 00h it sets a sticky overflow flag, which only a bus write changes. An enable bit passes the flag to `irq_o`. Any bus write to the counter blocks increments for the following two cycles, so software that reloads the counter must allow for that lag. The watchdog reset action and sleep handling sit outside the block. It only supplies the scaled or unscaled time-base pulse on `wdt_ev_o`.

Top module: `tmr8_unit`

## Requirements
- R1: After reset the counter reads 00h, the control register reads 00h, and `irq_o` is 0.
- R2: With `src_ext_i`=0 and the prescaler assigned to the watchdog (`presc_wdt_i`=1), the counter advances by one each clock cycle and never by more than one between writes.
- R3: With `src_ext_i`=1 the counter counts pin edges: rising when `fall_edge_i`=0, falling when `fall_edge_i`=1. The other edge has no effect. A counted pin change shows in the counter after the third rising clock edge that follows it.
- R4: A bus write with `bus_addr_i`=0 loads `bus_wdata_i` into the counter. Increments are suppressed on the next two clock edges.
- R5: An increment from FFh wraps to 00h and sets the overflow flag (control bit 0). The flag stays set until a control write changes it.
- R6: `irq_o` is high exactly when both the overflow flag and the enable bit (control bit 1) are set.
- R7: A control write (`bus_addr_i`=1) that lands on the same edge as an overflow wins: the flag takes `bus_wdata_i[0]`.
- R8: With `presc_wdt_i`=0 the counter advances once every 2^(rate+1) source events (1:2 at rate 0 to 1:256 at rate 7). `wdt_ev_o` then follows `wdt_tick_i` unscaled.
- R9: With `presc_wdt_i`=1, `wdt_ev_o` pulses on one `wdt_tick_i` in every 2^rate (1:1 to 1:128), and only on a cycle where `wdt_tick_i` is high.
- R10: A counter write while `presc_wdt_i`=0 clears the prescaler, so the next period starts with a full count of source events.
- R11: `bus_rdata_o` shows the counter when `bus_addr_i`=0 and {6'b0, enable, flag} when `bus_addr_i`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Instruction-cycle clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_ext_i | input | 1 | 0: count cycles, 1: count pin edges |
| fall_edge_i | input | 1 | 0: rising pin edge, 1: falling pin edge |
| presc_wdt_i | input | 1 | 0: prescaler on counter, 1: prescaler on watchdog path |
| rate_i | input | 3 | Prescaler stage select |
| pin_i | input | 1 | External count pin, asynchronous |
| wdt_tick_i | input | 1 | Watchdog time-base tick |
| bus_we_i | input | 1 | Bus write strobe |
| bus_addr_i | input | 1 | 0: counter, 1: control |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for the addressed register |
| irq_o | output | 1 | Overflow interrupt |
| wdt_ev_o | output | 1 | Time-base pulse toward the watchdog |

## Verification
Assertions check on every cycle that the counter never jumps by more than one unless written, the write load and both held edges after it, that the flag rises only on a wrap or a control write and then holds, control-write priority over an overflow, interrupt gating, and that a scaled watchdog pulse always coincides with a tick. Only the bench scenarios can show the counting ratios: each rate in both prescaler assignments, the prescaler clear on reload, the exact three-edge latency of a pin edge, and the polarity in which the unselected edge is ignored. A cycle-level reference model runs under directed and seeded random stimulus to compare these.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;
  localparam int unsigned CNT_W_DEF  = 8;
  localparam int unsigned PRE_W_DEF  = 8;
  localparam int unsigned SYNC_N_DEF = 2;
  localparam int unsigned HOLD_N_DEF = 2;

  typedef enum logic {
    ADDR_CNT = 1'b0,
    ADDR_CTL = 1'b1
  } reg_addr_e;

  // control register bit positions
  localparam int unsigned CTL_FLAG = 0;
  localparam int unsigned CTL_IEN  = 1;
endpackage

// File: rtl/tmr8_pin_sync.sv
module tmr8_pin_sync #(
  parameter int unsigned SYNC_N = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic fall_sel_i,
  output logic edge_o
);
  // SYNC_N synchronizer stages plus one delayed copy for edge detect
  logic [SYNC_N:0] sh_q;
  logic            cur, prev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[SYNC_N-1:0], pin_i};
  end

  assign cur    = sh_q[SYNC_N-1];
  assign prev   = sh_q[SYNC_N];
  assign edge_o = fall_sel_i ? (prev & ~cur) : (cur & ~prev);
endmodule

// File: rtl/tmr8_prescaler.sv
module tmr8_prescaler #(
  parameter  int unsigned PRE_W  = 8,
  localparam int unsigned RATE_W = $clog2(PRE_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ev_i,
  input  logic              clr_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic              end_ctr_o,
  output logic              end_wdt_o
);
  localparam int unsigned RW1 = RATE_W + 1;

  logic [PRE_W-1:0] pcnt_q;
  logic [PRE_W-1:0] mask_ctr, mask_wdt;

  // counter path taps one stage deeper than the watchdog path
  for (genvar i = 0; i < PRE_W; i++) begin : g_mask
    assign mask_ctr[i] = RW1'(i) <= {1'b0, rate_i};
    assign mask_wdt[i] = RW1'(i) <  {1'b0, rate_i};
  end

  assign end_ctr_o = &(pcnt_q | ~mask_ctr);
  assign end_wdt_o = &(pcnt_q | ~mask_wdt);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   pcnt_q <= '0;
    else if (clr_i) pcnt_q <= '0;
    else if (ev_i)  pcnt_q <= pcnt_q + PRE_W'(1);
  end
endmodule

// File: rtl/tmr8_core.sv
module tmr8_core #(
  parameter  int unsigned CNT_W  = 8,
  parameter  int unsigned HOLD_N = 2,
  localparam int unsigned HOLD_W = $clog2(HOLD_N + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             wr_cnt_i,
  input  logic             wr_ctl_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             flag_o,
  output logic             ien_o
);
  logic [CNT_W-1:0]  cnt_q;
  logic [HOLD_W-1:0] hold_q;
  logic              flag_q, ien_q, ovf;

  assign ovf = inc_i & ~wr_cnt_i & (hold_q == '0) & (&cnt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      hold_q <= '0;
    end else if (wr_cnt_i) begin
      cnt_q  <= wdata_i;
      hold_q <= HOLD_W'(HOLD_N);
    end else if (hold_q != '0) begin
      hold_q <= hold_q - HOLD_W'(1);
    end else if (inc_i) begin
      cnt_q  <= cnt_q + CNT_W'(1);
    end
  end

  // software write beats a same-edge overflow
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      ien_q  <= 1'b0;
    end else if (wr_ctl_i) begin
      flag_q <= wdata_i[tmr8_pkg::CTL_FLAG];
      ien_q  <= wdata_i[tmr8_pkg::CTL_IEN];
    end else if (ovf) begin
      flag_q <= 1'b1;
    end
  end

  assign cnt_o  = cnt_q;
  assign flag_o = flag_q;
  assign ien_o  = ien_q;
endmodule

// File: rtl/tmr8_unit.sv
module tmr8_unit #(
  parameter  int unsigned CNT_W  = tmr8_pkg::CNT_W_DEF,
  parameter  int unsigned PRE_W  = tmr8_pkg::PRE_W_DEF,
  parameter  int unsigned SYNC_N = tmr8_pkg::SYNC_N_DEF,
  parameter  int unsigned HOLD_N = tmr8_pkg::HOLD_N_DEF,
  localparam int unsigned RATE_W = $clog2(PRE_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              src_ext_i,
  input  logic              fall_edge_i,
  input  logic              presc_wdt_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic              pin_i,
  input  logic              wdt_tick_i,
  input  logic              bus_we_i,
  input  logic              bus_addr_i,
  input  logic [CNT_W-1:0]  bus_wdata_i,
  output logic [CNT_W-1:0]  bus_rdata_o,
  output logic              irq_o,
  output logic              wdt_ev_o
);
  import tmr8_pkg::*;

  logic             pin_edge, src_ev, pre_ev, inc;
  logic             end_ctr, end_wdt;
  logic             wr_cnt, wr_ctl, pre_clr;
  logic [CNT_W-1:0] cnt_w;
  logic             flag_w, ien_w;

  assign wr_cnt  = bus_we_i & (bus_addr_i == ADDR_CNT);
  assign wr_ctl  = bus_we_i & (bus_addr_i == ADDR_CTL);
  assign pre_clr = wr_cnt & ~presc_wdt_i;

  tmr8_pin_sync #(.SYNC_N(SYNC_N)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pin_i      (pin_i),
    .fall_sel_i (fall_edge_i),
    .edge_o     (pin_edge)
  );

  assign src_ev = src_ext_i ? pin_edge : 1'b1;
  assign pre_ev = presc_wdt_i ? wdt_tick_i : src_ev;

  tmr8_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ev_i      (pre_ev),
    .clr_i     (pre_clr),
    .rate_i    (rate_i),
    .end_ctr_o (end_ctr),
    .end_wdt_o (end_wdt)
  );

  assign inc      = presc_wdt_i ? src_ev : (src_ev & end_ctr);
  assign wdt_ev_o = presc_wdt_i ? (wdt_tick_i & end_wdt) : wdt_tick_i;

  tmr8_core #(.CNT_W(CNT_W), .HOLD_N(HOLD_N)) u_core (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .inc_i    (inc),
    .wr_cnt_i (wr_cnt),
    .wr_ctl_i (wr_ctl),
    .wdata_i  (bus_wdata_i),
    .cnt_o    (cnt_w),
    .flag_o   (flag_w),
    .ien_o    (ien_w)
  );

  assign irq_o       = flag_w & ien_w;
  assign bus_rdata_o = (bus_addr_i == ADDR_CTL) ? {{(CNT_W-2){1'b0}}, ien_w, flag_w} : cnt_w;
endmodule

// File: rtl/tmr8_unit_chk.sv
module tmr8_unit_chk #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             bus_we_i,
  input logic             bus_addr_i,
  input logic [CNT_W-1:0] bus_wdata_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic             flag_i,
  input logic             ien_i,
  input logic             irq_o,
  input logic             wdt_tick_i,
  input logic             wdt_ev_o
);
  logic wr_cnt, wr_ctl;
  assign wr_cnt = bus_we_i & ~bus_addr_i;
  assign wr_ctl = bus_we_i &  bus_addr_i;

  // R2
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_cnt |=> (cnt_i == $past(cnt_i) || cnt_i == $past(cnt_i) + CNT_W'(1)));

  // R4
  cnt_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_cnt |=> cnt_i == $past(bus_wdata_i));

  // R4
  hold_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_cnt ##1 !wr_cnt |=> $stable(cnt_i));

  // R4
  hold_second_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_cnt ##1 !wr_cnt ##1 !wr_cnt |=> $stable(cnt_i));

  // R5
  flag_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_i) |-> ($past(wr_ctl) || ($past(cnt_i) == '1 && cnt_i == '0)));

  // R5
  flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_i && !wr_ctl) |=> flag_i);

  // R7
  ctl_prio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ctl |=> flag_i == $past(bus_wdata_i[0]));

  // R6
  irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (ien_i && flag_i));

  // R9
  wdt_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_ev_o |-> wdt_tick_i);
endmodule

bind tmr8_unit tmr8_unit_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_we_i    (bus_we_i),
  .bus_addr_i  (bus_addr_i),
  .bus_wdata_i (bus_wdata_i),
  .cnt_i       (cnt_w),
  .flag_i      (flag_w),
  .ien_i       (ien_w),
  .irq_o       (irq_o),
  .wdt_tick_i  (wdt_tick_i),
  .wdt_ev_o    (wdt_ev_o)
);

// File: tb/sim_tmr8_unit.sv
module sim_tmr8_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       src_ext = 1'b0, fall = 1'b0, pwdt = 1'b1;
  logic [2:0] rate = 3'd0;
  logic       pin = 1'b0, tick = 1'b0;
  logic       we = 1'b0, addr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       irq, wdt_ev;

  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  tmr8_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .src_ext_i(src_ext), .fall_edge_i(fall),
    .presc_wdt_i(pwdt), .rate_i(rate), .pin_i(pin), .wdt_tick_i(tick),
    .bus_we_i(we), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .irq_o(irq), .wdt_ev_o(wdt_ev)
  );

  // reference model state
  logic [7:0] m_cnt;
  logic       m_flag, m_ien, m_s1, m_s2, m_s3;
  int         m_hold, m_p;

  function automatic int f_ratio(logic [2:0] r, logic to_wdt);
    return to_wdt ? (1 << r) : (2 << r);
  endfunction

  function automatic logic f_period_end(int p, logic [2:0] r, logic to_wdt);
    return ((p + 1) % f_ratio(r, to_wdt)) == 0;
  endfunction

  function automatic logic [7:0] f_rd(logic a);
    return a ? {6'b0, m_ien, m_flag} : m_cnt;
  endfunction

  always @(posedge clk or negedge rst_n) begin : model
    logic src, pev, ctick;
    if (!rst_n) begin
      m_cnt <= 8'h00; m_flag <= 1'b0; m_ien <= 1'b0;
      m_s1 <= 1'b0; m_s2 <= 1'b0; m_s3 <= 1'b0;
      m_hold <= 0; m_p <= 0;
    end else begin
      src   = src_ext ? (fall ? (!m_s2 && m_s3) : (m_s2 && !m_s3)) : 1'b1;
      pev   = pwdt ? tick : src;
      ctick = pwdt ? src : (src && f_period_end(m_p, rate, 1'b0));
      m_s1 <= pin; m_s2 <= m_s1; m_s3 <= m_s2;
      if (we && !addr && !pwdt) m_p <= 0;
      else if (pev)             m_p <= (m_p + 1) % 256;
      if (we && !addr) begin
        m_cnt <= wdata; m_hold <= 2;
      end else if (m_hold > 0) begin
        m_hold <= m_hold - 1;
      end else if (ctick) begin
        m_cnt <= m_cnt + 8'd1;
        if (m_cnt == 8'hFF && !(we && addr)) m_flag <= 1'b1;
      end
      if (we && addr) begin
        m_flag <= wdata[0]; m_ien <= wdata[1];
      end
    end
  end

  task automatic chk(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %02h expected %02h", tag, what, act, exp);
    end
  endtask

  // sample outputs, then drive next inputs
  task automatic step(input string tag, input logic we_, input logic a_, input logic [7:0] wd_,
                      input logic pin_, input logic tick_);
    logic exp_w;
    @(negedge clk);
    chk(tag, "rdata", rdata, f_rd(addr));
    chk(tag, "irq", {7'b0, irq}, {7'b0, m_flag & m_ien});
    we = we_; addr = a_; wdata = wd_; pin = pin_; tick = tick_;
    exp_w = pwdt ? (tick_ && f_period_end(m_p, rate, 1'b1)) : tick_;
    #1;
    chk(tag, "wdt_ev", {7'b0, wdt_ev}, {7'b0, exp_w});
  endtask

  task automatic idle(input string tag, input int n);
    for (int i = 0; i < n; i++) step(tag, 1'b0, 1'b0, 8'h00, pin, 1'b0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    void'($urandom(32'h5EED_0042));
    repeat (3) @(posedge clk);
    #3 rst_n = 1'b1;

    // R1 reset state
    @(negedge clk);
    chk("R1", "cnt", rdata, 8'h00);
    addr = 1'b1; #1;
    chk("R1", "ctl", rdata, 8'h00);
    chk("R1", "irq", {7'b0, irq}, 8'h00);
    addr = 1'b0;

    // R2 free running, prescaler on watchdog
    idle("R2", 20);

    // R4 load and two-edge holdoff
    step("R4", 1'b1, 1'b0, 8'h10, 1'b0, 1'b0);
    step("R4", 1'b0, 1'b0, 8'h00, 1'b0, 1'b0); chk("R4", "load", rdata, 8'h10);
    step("R4", 1'b0, 1'b0, 8'h00, 1'b0, 1'b0); chk("R4", "hold1", rdata, 8'h10);
    step("R4", 1'b0, 1'b0, 8'h00, 1'b0, 1'b0); chk("R4", "hold2", rdata, 8'h10);
    step("R4", 1'b0, 1'b0, 8'h00, 1'b0, 1'b0); chk("R4", "resume", rdata, 8'h11);

    // R5 R6 overflow flag and interrupt gate
    step("R6", 1'b1, 1'b1, 8'h02, 1'b0, 1'b0);
    step("R5", 1'b1, 1'b0, 8'hFC, 1'b0, 1'b0);
    idle("R5", 10);
    addr = 1'b1; #1;
    chk("R5", "flag set", rdata, 8'h03);
    chk("R6", "irq on", {7'b0, irq}, 8'h01);
    addr = 1'b0;
    idle("R5", 8);
    step("R6", 1'b1, 1'b1, 8'h01, 1'b0, 1'b0);
    step("R6", 1'b0, 1'b1, 8'h00, 1'b0, 1'b0);
    chk("R6", "irq masked", {7'b0, irq}, 8'h00);
    chk("R11", "ctl read", rdata, 8'h01);
    step("R5", 1'b1, 1'b1, 8'h00, 1'b0, 1'b0);

    // R7 control write on the overflow edge
    step("R7", 1'b1, 1'b0, 8'hFE, 1'b0, 1'b0);
    idle("R7", 3);
    step("R7", 1'b1, 1'b1, 8'h02, 1'b0, 1'b0);
    step("R7", 1'b0, 1'b1, 8'h00, 1'b0, 1'b0);
    chk("R7", "flag after clash", rdata, 8'h02);
    addr = 1'b0; #1;
    chk("R7", "wrapped", rdata, 8'h00);

    // R8 R10 every ratio with prescaler on the counter
    pwdt = 1'b0;
    for (int r = 0; r < 8; r++) begin
      rate = 3'(r);
      step("R10", 1'b1, 1'b0, 8'h00, 1'b0, 1'b0);
      for (int k = 0; k < f_ratio(3'(r), 1'b0) * 3 + 4; k++)
        step("R8", 1'b0, 1'b0, 8'h00, 1'b0, $urandom_range(0, 1) == 1);
    end
    rate = 3'd2;
    step("R10", 1'b1, 1'b0, 8'h00, 1'b0, 1'b0);
    idle("R10", 8);
    chk("R10", "before period", rdata, 8'h00);
    idle("R10", 1);
    chk("R10", "after period", rdata, 8'h01);

    // R9 watchdog ratios
    pwdt = 1'b1;
    for (int r = 0; r < 8; r++) begin
      rate = 3'(r);
      for (int k = 0; k < f_ratio(3'(r), 1'b1) * 4 + 4; k++)
        step("R9", 1'b0, 1'b0, 8'h00, 1'b0, $urandom_range(0, 2) != 0);
    end

    // R3 edge polarity and latency
    src_ext = 1'b1; fall = 1'b1;
    step("R3", 1'b1, 1'b0, 8'h20, 1'b0, 1'b0);
    idle("R3", 4);
    step("R3", 1'b0, 1'b0, 8'h00, 1'b1, 1'b0);
    idle("R3", 5);
    chk("R3", "rise ignored", rdata, 8'h20);
    step("R3", 1'b0, 1'b0, 8'h00, 1'b0, 1'b0);
    idle("R3", 2);
    chk("R3", "fall pending", rdata, 8'h20);
    idle("R3", 1);
    chk("R3", "fall counted", rdata, 8'h21);
    fall = 1'b0;
    for (int k = 0; k < 200; k++)
      step("R3", 1'b0, 1'b0, 8'h00, ($urandom_range(0, 2) == 0) ? ~pin : pin, 1'b0);
    fall = 1'b1;
    for (int k = 0; k < 200; k++)
      step("R3", 1'b0, 1'b0, 8'h00, ($urandom_range(0, 2) == 0) ? ~pin : pin, 1'b0);

    // random mix
    for (int k = 0; k < 3000; k++) begin
      if (k % 64 == 0) begin
        src_ext = 1'($urandom_range(0, 1)); fall = 1'($urandom_range(0, 1));
        pwdt = 1'($urandom_range(0, 1)); rate = 3'($urandom_range(0, 7));
      end
      step("R11", $urandom_range(0, 15) == 0, 1'($urandom_range(0, 1)), 8'($urandom_range(0, 255)),
           ($urandom_range(0, 2) == 0) ? ~pin : pin, 1'($urandom_range(0, 1)));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule